// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the target side of a four-wire serial link for a flash device. It takes chip select, serial clock and serial data in from a host, and turns each select cycle into parallel transactions for a storage back end. It decodes two commands: program (0x02) and read (0x03). Each command is followed by a three-byte address. A program produces one write strobe per complete data byte. A read fetches bytes from the back end and shifts them out on the serial output. The serial output is driven only while a read is under way; at all other times it floats.

All pins are sampled with the system clock through synchronizers, so the whole block runs in one clock domain. Serial clock edges are found by edge detection. This means both serial clock idle levels (mode 0, idle low; mode 3, idle high) are handled by the same logic. The back end answers a read request with its data on the clock cycle after the request. That timing matches a registered memory.

Top module: `spiflash_cmd_fe`

## Requirements
- R1: Bits on `spi_mosi` are taken at rising `spi_sck` edges, most significant bit first. This works the same whether `spi_sck` idles low (mode 0) or high (mode 3).
- R2: After opcode 0x02 and three address bytes, `cmd_valid` pulses with `cmd_is_read`=0, and `be_rd_req` stays low. Each following complete byte gives one `be_wr_valid` pulse with that byte on `be_wdata`. The write address starts at the received address. Its low 8 bits then increment per byte and wrap inside the 256-byte page; the upper bits do not change.
- R3: After opcode 0x03 and three address bytes, `cmd_valid` pulses with `cmd_is_read`=1 and `be_rd_req` in the same cycle. The fetched bytes are sent on `spi_miso`, most significant bit first. Each bit changes after a falling `spi_sck` edge. The next byte is requested at the falling edge that sends the last bit of the current byte. Read addresses increment and wrap from 0xFFFFF to 0x00000. For N complete bytes read, there are N+1 requests.
- R4: Address bits 23..20 are discarded; `be_addr` and `cmd_valid`'s address carry bits 19..0.
- R5: An opcode other than 0x02 or 0x03 produces no strobe and no drive on `spi_miso` for the rest of that select cycle, whatever bytes follow.
- R6: If select is released before the opcode and all three address bytes have arrived, no `cmd_valid`, `be_wr_valid` or `be_rd_req` is produced.
- R7: Releasing select clears any partial byte. The next select cycle decodes its opcode from its own first eight bits.
- R8: `spi_miso_oe` is high only during a read after the address. `spi_miso` is high impedance whenever `spi_miso_oe` is low. `spi_miso_oe` falls within four clock cycles of select being released.
- R9: While `rst` is high, all strobes and `spi_miso_oe` are low and `spi_miso` is high impedance.
- R10: `be_wr_valid` and `be_rd_req` are single-cycle pulses and never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, high impedance when not driven |
| spi_miso_oe | output | 1 | High while `spi_miso` is driven |
| cmd_valid | output | 1 | One-cycle pulse when a command and its address are complete |
| cmd_is_read | output | 1 | Command type with `cmd_valid`: 1 read, 0 program |
| be_addr | output | ADDR_W | Back-end address for command, write or read request |
| be_wr_valid | output | 1 | One-cycle write strobe |
| be_wdata | output | 8 | Write data with `be_wr_valid` |
| be_rd_req | output | 1 | One-cycle read request |
| be_rdata | input | 8 | Read data, valid the cycle after `be_rd_req` |

## Verification
Each pin passes two synchronizer stages and an edge detector. A strobe or serial output change therefore follows the causing `spi_sck` edge by about four to six clock cycles. The fetched byte must be loaded before the next falling edge. The bench holds each `spi_sck` phase for eight clock cycles and drives inputs on the falling clock edge. It samples `spi_miso` at the end of each low phase, just before raising `spi_sck`, which is well after the output has settled. Strobe counts and addresses are compared only after select has been released and a settling gap of sixteen clock cycles has passed.

// File: rtl/spiflash_pkg.sv
package spiflash_pkg;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_PROGRAM,
    ST_READ,
    ST_IGNORE
  } fe_state_e;

  localparam logic [7:0] OPC_PROGRAM = 8'h02;
  localparam logic [7:0] OPC_READ    = 8'h03;

endpackage

// File: rtl/spiflash_sync.sv
module spiflash_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_VAL[g]}};
      else     pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/spiflash_rxshift.sv
module spiflash_rxshift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rise,
  input  logic              din,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      bit_cnt  <= '0;
      sr       <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (rise) begin
        sr <= {sr[BYTE_W-2:0], din};
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          byte_vld <= 1'b1;
          byte_q   <= {sr[BYTE_W-2:0], din};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spiflash_txshift.sv
module spiflash_txshift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              fall,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              tx_bit,
  output logic              need_next
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  out_cnt;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      out_cnt   <= '0;
      sh        <= '0;
      tx_bit    <= 1'b0;
      need_next <= 1'b0;
    end else begin
      need_next <= 1'b0;
      if (load) begin
        sh <= load_data;
      end else if (fall) begin
        tx_bit <= sh[BYTE_W-1];
        sh     <= {sh[BYTE_W-2:0], 1'b0};
        if (out_cnt == LAST) begin
          out_cnt   <= '0;
          need_next <= 1'b1;
        end else begin
          out_cnt <= out_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spiflash_cmd_fe.sv
module spiflash_cmd_fe
  import spiflash_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int ADDR_BYTES  = 3,
  parameter int PAGE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              cmd_valid,
  output logic              cmd_is_read,
  output logic [ADDR_W-1:0] be_addr,
  output logic              be_wr_valid,
  output logic [7:0]        be_wdata,
  output logic              be_rd_req,
  input  logic [7:0]        be_rdata
);

  localparam int BYTE_W = 8;
  localparam int AB_W   = $clog2(ADDR_BYTES);
  localparam logic [AB_W-1:0] AB_LAST = AB_W'(ADDR_BYTES - 1);

  logic [2:0] pins_s;
  logic       cs_n_s, sck_s, mosi_s, sck_d;
  logic       sel, sck_rise, sck_fall;

  spiflash_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({spi_cs_n, spi_sck, spi_mosi}),
    .dout(pins_s)
  );

  assign {cs_n_s, sck_s, mosi_s} = pins_s;
  assign sel = !cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;

  logic             rx_vld;
  logic [BYTE_W-1:0] rx_byte;

  spiflash_rxshift #(.BYTE_W(BYTE_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .rise    (sck_rise),
    .din     (mosi_s),
    .byte_vld(rx_vld),
    .byte_q  (rx_byte)
  );

  fe_state_e         st;
  logic [AB_W-1:0]   ab_cnt;
  logic [ADDR_W-1:0] addr_sh, addr_q, asm_addr;
  logic              rd_pend, oe_q, tx_bit, tx_need;

  assign asm_addr = {addr_sh[ADDR_W-BYTE_W-1:0], rx_byte};

  spiflash_txshift #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .active   (st == ST_READ),
    .fall     (sck_fall),
    .load     (rd_pend),
    .load_data(be_rdata),
    .tx_bit   (tx_bit),
    .need_next(tx_need)
  );

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      st          <= ST_OPCODE;
      ab_cnt      <= '0;
      addr_sh     <= '0;
      cmd_valid   <= 1'b0;
      cmd_is_read <= 1'b0;
      be_wr_valid <= 1'b0;
      be_rd_req   <= 1'b0;
      rd_pend     <= 1'b0;
      oe_q        <= 1'b0;
      if (rst) begin
        addr_q   <= '0;
        be_addr  <= '0;
        be_wdata <= '0;
      end
    end else begin
      cmd_valid   <= 1'b0;
      be_wr_valid <= 1'b0;
      be_rd_req   <= 1'b0;
      rd_pend     <= be_rd_req;
      oe_q        <= (st == ST_READ);
      if (rx_vld) begin
        case (st)
          ST_OPCODE: begin
            if (rx_byte == OPC_PROGRAM) begin
              st          <= ST_ADDR;
              cmd_is_read <= 1'b0;
            end else if (rx_byte == OPC_READ) begin
              st          <= ST_ADDR;
              cmd_is_read <= 1'b1;
            end else begin
              st <= ST_IGNORE;
            end
          end
          ST_ADDR: begin
            addr_sh <= asm_addr;
            ab_cnt  <= ab_cnt + 1'b1;
            if (ab_cnt == AB_LAST) begin
              cmd_valid <= 1'b1;
              be_addr   <= asm_addr;
              if (cmd_is_read) begin
                be_rd_req <= 1'b1;
                addr_q    <= asm_addr + 1'b1;
                st        <= ST_READ;
              end else begin
                addr_q <= asm_addr;
                st     <= ST_PROGRAM;
              end
            end
          end
          ST_PROGRAM: begin
            be_wr_valid          <= 1'b1;
            be_addr              <= addr_q;
            be_wdata             <= rx_byte;
            addr_q[PAGE_W-1:0]   <= addr_q[PAGE_W-1:0] + 1'b1;
          end
          default: ;
        endcase
      end
      if (st == ST_READ && tx_need) begin
        be_rd_req <= 1'b1;
        be_addr   <= addr_q;
        addr_q    <= addr_q + 1'b1;
      end
    end
  end

  assign spi_miso_oe = oe_q;
  assign spi_miso    = oe_q ? tx_bit : 1'bz;

endmodule

// File: rtl/spiflash_cmd_fe_chk.sv
module spiflash_cmd_fe_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_miso_oe,
  input logic cmd_valid,
  input logic cmd_is_read,
  input logic be_wr_valid,
  input logic be_rd_req
);

  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(be_wr_valid && be_rd_req)); // R10

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    be_wr_valid |=> !be_wr_valid); // R10

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    be_rd_req |=> !be_rd_req); // R10

  AST_READ_CMD_FETCH: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_is_read) |-> be_rd_req); // R3

  AST_PROG_CMD_NOFETCH: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_is_read) |-> !be_rd_req); // R2

  AST_OE_DROP: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso_oe); // R8

  AST_NO_WR_WHILE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    be_wr_valid |-> !spi_miso_oe); // R8

endmodule

bind spiflash_cmd_fe spiflash_cmd_fe_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .spi_cs_n   (spi_cs_n),
  .spi_miso_oe(spi_miso_oe),
  .cmd_valid  (cmd_valid),
  .cmd_is_read(cmd_is_read),
  .be_wr_valid(be_wr_valid),
  .be_rd_req  (be_rd_req)
);

// File: tb/sim_spiflash_cmd_fe.sv
module sim_spiflash_cmd_fe;

  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int NVEC  = 7;

  // {mode3, opcode, addr24, seed, ndata}
  localparam logic [44:0] VEC [0:NVEC-1] = '{
    {1'b0, 8'h02, 24'h000010, 8'hA0, 4'd3},
    {1'b1, 8'h02, 24'hF123FE, 8'h33, 4'd4},
    {1'b0, 8'h03, 24'h0ABCDE, 8'h11, 4'd3},
    {1'b1, 8'h03, 24'hAFFFFE, 8'h22, 4'd3},
    {1'b0, 8'h9F, 24'h020000, 8'h02, 4'd2},
    {1'b1, 8'h00, 24'h030000, 8'h10, 4'd2},
    {1'b1, 8'h03, 24'h000000, 8'hFF, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_cs_n = 1'b1;
  logic        spi_sck = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe, cmd_valid, cmd_is_read;
  logic [19:0] be_addr;
  logic        be_wr_valid, be_rd_req;
  logic [7:0]  be_wdata;
  logic [7:0]  be_rdata = 8'h00;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  spiflash_cmd_fe u0 (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read), .be_addr(be_addr),
    .be_wr_valid(be_wr_valid), .be_wdata(be_wdata), .be_rd_req(be_rd_req),
    .be_rdata(be_rdata)
  );

  function automatic logic [7:0] mdl(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
  endfunction

  // back-end model and monitors
  int wr_n = 0, rd_n = 0, cmd_n = 0, oe_n = 0;
  logic [19:0] wr_addr [0:63];
  logic [7:0]  wr_data [0:63];
  logic [19:0] cmd_addr;
  logic        cmd_rd;

  always @(posedge clk) begin
    if (be_rd_req) be_rdata <= mdl(be_addr);
    if (!rst) begin
      if (be_wr_valid) begin
        wr_addr[wr_n % 64] <= be_addr;
        wr_data[wr_n % 64] <= be_wdata;
        wr_n <= wr_n + 1;
      end
      if (be_rd_req) rd_n <= rd_n + 1;
      if (cmd_valid) begin
        cmd_n    <= cmd_n + 1;
        cmd_addr <= be_addr;
        cmd_rd   <= cmd_is_read;
      end
      if (spi_miso_oe) oe_n <= oe_n + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [7:0] tx_buf [0:15];
  logic [7:0] rx_buf [0:15];

  task automatic xact(input bit m3, input int nbits);
    spi_sck = m3;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sck  = 1'b0;
      spi_mosi = tx_buf[i/8][7 - (i%8)];
      repeat (HALF) @(negedge clk);
      rx_buf[i/8][7 - (i%8)] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    if (!m3) spi_sck = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int wb, rb, cb, ob;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "oe in reset", {31'd0, spi_miso_oe}, 32'd0);
    chk("R9", "miso z in reset", {31'd0, spi_miso === 1'bz}, 32'd1);
    chk("R9", "strobes in reset",
        {29'd0, cmd_valid, be_wr_valid, be_rd_req}, 32'd0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic        m3;
      logic [7:0]  op, seed;
      logic [23:0] a24;
      int          n;
      bit          sup, rd;
      {m3, op, a24, seed} = VEC[v][44:4];
      n   = int'(VEC[v][3:0]);
      sup = (op == 8'h02) || (op == 8'h03);
      rd  = (op == 8'h03);
      tx_buf[0] = op;
      tx_buf[1] = a24[23:16];
      tx_buf[2] = a24[15:8];
      tx_buf[3] = a24[7:0];
      for (int k = 0; k < n; k++) tx_buf[4+k] = seed + 8'(k);
      wb = wr_n; rb = rd_n; cb = cmd_n; ob = oe_n;
      xact(m3, 8*(4+n));
      // R1 (mode chosen by m3) R2 R3 R5: command strobe count
      chk(sup ? (rd ? "R3" : "R2") : "R5", "cmd count",
          32'(cmd_n - cb), sup ? 32'd1 : 32'd0);
      if (sup) begin
        chk("R4", "cmd address", {12'd0, cmd_addr}, {12'd0, a24[19:0]});
        chk("R1", "cmd type", {31'd0, cmd_rd}, {31'd0, rd});
      end
      if (sup && !rd) begin
        chk("R2", "write count", 32'(wr_n - wb), 32'(n));
        chk("R2", "read count", 32'(rd_n - rb), 32'd0);
        chk("R8", "oe during program", 32'(oe_n - ob), 32'd0);
        for (int k = 0; k < n; k++) begin
          chk("R2", "write address", {12'd0, wr_addr[(wb+k)%64]},
              {12'd0, a24[19:8], a24[7:0] + 8'(k)});
          chk("R2", "write data", {24'd0, wr_data[(wb+k)%64]},
              {24'd0, seed + 8'(k)});
        end
      end else if (rd) begin
        chk("R3", "read requests", 32'(rd_n - rb), 32'(n + 1));
        chk("R3", "writes during read", 32'(wr_n - wb), 32'd0);
        chk("R8", "oe seen in read", {31'd0, (oe_n - ob) > 0}, 32'd1);
        for (int k = 0; k < n; k++)
          chk("R3", "read byte", {24'd0, rx_buf[4+k]},
              {24'd0, mdl(a24[19:0] + 20'(k))});
      end else begin
        chk("R5", "writes after bad opcode", 32'(wr_n - wb), 32'd0);
        chk("R5", "reads after bad opcode", 32'(rd_n - rb), 32'd0);
        chk("R5", "oe after bad opcode", 32'(oe_n - ob), 32'd0);
      end
      chk("R8", "oe low after release", {31'd0, spi_miso_oe}, 32'd0);
      chk("R8", "miso z after release", {31'd0, spi_miso === 1'bz}, 32'd1);
    end

    // R6: select released after two address bytes
    tx_buf[0] = 8'h02; tx_buf[1] = 8'h00; tx_buf[2] = 8'h12; tx_buf[3] = 8'h34;
    wb = wr_n; rb = rd_n; cb = cmd_n;
    xact(1'b0, 24);
    chk("R6", "cmd after short address", 32'(cmd_n - cb), 32'd0);
    chk("R6", "strobes after short address",
        32'((wr_n - wb) + (rd_n - rb)), 32'd0);

    // R6: select released in the middle of the last address byte
    cb = cmd_n;
    xact(1'b1, 29);
    chk("R6", "cmd after cut address", 32'(cmd_n - cb), 32'd0);

    // R7: partial opcode then a clean program
    tx_buf[0] = 8'hFF;
    xact(1'b0, 5);
    tx_buf[0] = 8'h02; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    tx_buf[3] = 8'h40; tx_buf[4] = 8'h77;
    wb = wr_n; cb = cmd_n;
    xact(1'b0, 40);
    chk("R7", "cmd after partial byte", 32'(cmd_n - cb), 32'd1);
    chk("R7", "write after partial byte", 32'(wr_n - wb), 32'd1);
    chk("R7", "write address", {12'd0, wr_addr[wb%64]}, 32'h40);
    chk("R7", "write data", {24'd0, wr_data[wb%64]}, 32'h77);

    // R5: unknown opcode followed by a full program sequence
    tx_buf[0] = 8'hAB; tx_buf[1] = 8'h02; tx_buf[2] = 8'h00;
    tx_buf[3] = 8'h00; tx_buf[4] = 8'h10; tx_buf[5] = 8'h55;
    wb = wr_n; cb = cmd_n;
    xact(1'b1, 48);
    chk("R5", "embedded program ignored", 32'((wr_n - wb) + (cmd_n - cb)), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule